// File: doc/BRIEF.md
# Snooping MOESI Coherence Controller

This block is the coherence controller of one private, write-back, direct-mapped cache that shares a snooping bus with other caches. It accepts one processor read or write at a time, serves it from a local line when the line's state allows, and otherwise requests the shared bus. Once granted, it broadcasts a read, a read-for-ownership, an ownership upgrade or a write-back for that line. Each line holds a tag, one data word and one of five coherence states: Invalid, Shared, Exclusive, Owned or Modified.

On the same bus the controller watches the transactions that other caches issue. A read or read-for-ownership that hits a valid line raises the shared response. If the local copy is dirty, the controller also supplies the data, and memory's answer is discarded. Ownership requests and upgrades from other caches invalidate the local copy. A dirty line read by another cache turns Owned, so it can be shared while memory still holds a stale value. That dirty data reaches memory only when the line is evicted.

The bus is single-phase. In the cycle the controller holds the grant, it drives its command and address. In that same cycle the system returns the read data and the OR of the other caches' shared responses. Snoop inputs carry the bus traffic of other caches, and the controller ignores them while it holds the grant itself.

Top module: `snoop_moesi_ctrl`

## Requirements
- R1: After reset every line is Invalid: bus_req and cpu_done are low, and a snooped read to any address gets neither snp_shared nor snp_supply.
- R2: A read that misses raises bus_req and, under grant, drives bus_cmd_o = 1 (read) with the request address. It returns bus_rdata_i on cpu_rdata with a one-cycle cpu_done pulse after that grant cycle. The line becomes Exclusive if bus_shared_i was 0 and Shared if it was 1.
- R3: A read that hits a valid line with a matching tag completes with no bus request. cpu_done is high in the cycle after the request is accepted.
- R4: A write that hits an Exclusive or Modified line completes with no bus transaction and leaves the line Modified.
- R5: A write that hits a Shared or Owned line issues bus_cmd_o = 3 (upgrade), and the line is then Modified.
- R6: A write that misses issues bus_cmd_o = 2 (read for ownership), stores the write data and leaves the line Modified.
- R7: A snooped read (snp_cmd = 1) turns an Exclusive line into Shared and a Modified line into Owned. An Owned line stays Owned. No write-back happens.
- R8: A snooped read or read-for-ownership (snp_cmd = 1 or 2) that hits a valid line asserts snp_shared in the same cycle. snp_supply and snp_data carry the line only when the line is Modified or Owned. A snoop whose tag differs from the stored tag gets no response, and neither does an upgrade (3) or a write-back (4).
- R9: A snooped read-for-ownership or upgrade that hits invalidates the line. A snooped write-back leaves it unchanged.
- R10: A miss whose victim line is Modified or Owned first issues bus_cmd_o = 4 (write-back) with the victim's address and data, then the miss command. A Shared or Exclusive victim is dropped without any bus transaction.
- R11: Snoop inputs have no effect in a cycle in which bus_gnt is high. A write that waits for the bus as an upgrade, and loses its copy to a snooped invalidation, issues a read for ownership instead.
- R12: bus_cmd_o is nonzero only while bus_gnt is high. Once raised, bus_req stays high until a grant arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Access address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_done |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus grant for the current cycle |
| bus_cmd_o | output | 3 | Command under grant: 0 none, 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back |
| bus_addr_o | output | ADDR_W | Address of the driven command |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_rdata_i | input | DATA_W | Line data returned in the grant cycle |
| bus_shared_i | input | 1 | OR of other caches' shared responses in the grant cycle |
| snp_cmd | input | 3 | Command another cache puts on the bus (same encoding) |
| snp_addr | input | ADDR_W | Address of the snooped command |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies the line; memory response is dropped |
| snp_data | output | DATA_W | Supplied line data |

## Verification
A wrong line state cannot be read out directly. It shows up as the wrong bus behaviour on the next access to that line. A stale Exclusive that should be Shared makes a later write go silent when it should issue an upgrade. A lost Owned state drops snp_supply on the next snooped read, and a missed dirty bit skips the write-back that a later read of the victim address depends on. Each such fault becomes visible at the ports within one access or one snoop after it occurs.

// File: rtl/moesi_pkg.sv
`timescale 1ns/1ps
package moesi_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_t;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_RD   = 3'd1,
    BC_RDX  = 3'd2,
    BC_UPG  = 3'd3,
    BC_WB   = 3'd4
  } bus_cmd_t;

  function automatic logic st_valid(input line_st_t s);
    return s != ST_I;
  endfunction

  function automatic logic st_dirty(input line_st_t s);
    return (s == ST_M) || (s == ST_O);
  endfunction

  // state after another cache's transaction hits the line
  function automatic line_st_t st_after_snoop(input line_st_t s, input bus_cmd_t c);
    line_st_t n;
    n = s;
    case (c)
      BC_RD: begin
        if (s == ST_M) n = ST_O;
        else if (s == ST_E) n = ST_S;
      end
      BC_RDX, BC_UPG: n = ST_I;
      default: n = s;
    endcase
    return n;
  endfunction

  // state after our own read fill
  function automatic line_st_t st_after_fill(input logic others_share);
    return others_share ? ST_S : ST_E;
  endfunction

  // bus command needed for a pending access
  function automatic bus_cmd_t cmd_for_access(input logic hit, input logic we,
                                              input line_st_t s);
    bus_cmd_t c;
    if (hit && we)          c = BC_UPG;
    else if (!hit && st_dirty(s)) c = BC_WB;
    else if (we)            c = BC_RDX;
    else                    c = BC_RD;
    return c;
  endfunction

endpackage

// File: rtl/moesi_line_array.sv
`timescale 1ns/1ps
module moesi_line_array
  import moesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  // local port: read and full write
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic              a_wen,
  input  line_st_t          a_wst,
  input  logic [TAG_W-1:0]  a_wtag,
  input  logic [DATA_W-1:0] a_wdata,
  // snoop port: read and state-only write
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              b_wen,
  input  line_st_t          b_wst
);

  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel_a, sel_b;
    assign sel_a = a_wen && (a_idx == IDX_W'(g));
    assign sel_b = b_wen && (b_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= ST_I;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (sel_a) begin
        st_q[g]   <= a_wst;
        tag_q[g]  <= a_wtag;
        data_q[g] <= a_wdata;
      end else if (sel_b) begin
        st_q[g]   <= b_wst;
      end
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];

endmodule

// File: rtl/moesi_snoop_unit.sv
`timescale 1ns/1ps
module moesi_snoop_unit
  import moesi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              en,
  input  bus_cmd_t          cmd,
  input  logic [TAG_W-1:0]  tag,
  input  line_st_t          l_st,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic [DATA_W-1:0] l_data,
  output logic              shared,
  output logic              supply,
  output logic [DATA_W-1:0] data,
  output logic              upd_en,
  output line_st_t          upd_st
);

  logic hit, is_read;

  assign hit     = en && st_valid(l_st) && (l_tag == tag);
  assign is_read = (cmd == BC_RD) || (cmd == BC_RDX);
  assign shared  = hit && is_read;
  assign supply  = shared && st_dirty(l_st);
  assign data    = supply ? l_data : '0;
  assign upd_en  = hit && (cmd != BC_WB) && (cmd != BC_NONE);
  assign upd_st  = st_after_snoop(l_st, cmd);

endmodule

// File: rtl/moesi_cmd_sel.sv
`timescale 1ns/1ps
module moesi_cmd_sel
  import moesi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             we,
  input  logic [TAG_W-1:0] tag,
  input  line_st_t         l_st,
  input  logic [TAG_W-1:0] l_tag,
  output logic             hit,
  output logic             local_ok,
  output bus_cmd_t         cmd
);

  assign hit      = st_valid(l_st) && (l_tag == tag);
  assign local_ok = hit && (!we || (l_st == ST_E) || (l_st == ST_M));
  assign cmd      = cmd_for_access(hit, we, l_st);

endmodule

// File: rtl/snoop_moesi_ctrl.sv
`timescale 1ns/1ps
module snoop_moesi_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);

  typedef enum logic {F_IDLE, F_REQ} fsm_t;

  fsm_t              fsm_q;
  logic              pend_we;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  logic              in_idle, in_req;
  logic [ADDR_W-1:0] c_addr;
  logic              c_we;
  logic [IDX_W-1:0]  c_idx;
  logic [TAG_W-1:0]  c_tag;

  line_st_t          ca_st, sb_st, a_wst, snp_nst;
  logic [TAG_W-1:0]  ca_tag, sb_tag, a_wtag;
  logic [DATA_W-1:0] ca_data, sb_data, a_wdata;
  logic              a_wen, snp_upd;
  logic              c_hit, c_local_ok;
  bus_cmd_t          c_cmd, s_cmd;
  logic              snp_en;

  // named events for the checker
  logic              evt_local_hit;
  logic              evt_bus_done;
  logic              evt_accept;

  assign in_idle = (fsm_q == F_IDLE);
  assign in_req  = (fsm_q == F_REQ);
  assign c_addr  = in_idle ? cpu_addr : pend_addr;
  assign c_we    = in_idle ? cpu_we   : pend_we;
  assign c_idx   = c_addr[IDX_W-1:0];
  assign c_tag   = c_addr[ADDR_W-1:IDX_W];
  assign s_cmd   = bus_cmd_t'(snp_cmd);
  assign snp_en  = (s_cmd != BC_NONE) && !bus_gnt;

  // a pending snoop takes the line arrays first; the local access waits
  assign evt_accept    = in_idle && cpu_req && (s_cmd == BC_NONE);
  assign evt_local_hit = evt_accept && c_local_ok;
  assign evt_bus_done  = in_req && bus_gnt;

  moesi_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_idx   (c_idx),
    .a_st    (ca_st),
    .a_tag   (ca_tag),
    .a_data  (ca_data),
    .a_wen   (a_wen),
    .a_wst   (a_wst),
    .a_wtag  (a_wtag),
    .a_wdata (a_wdata),
    .b_idx   (snp_addr[IDX_W-1:0]),
    .b_st    (sb_st),
    .b_tag   (sb_tag),
    .b_data  (sb_data),
    .b_wen   (snp_upd),
    .b_wst   (snp_nst)
  );

  moesi_cmd_sel #(.TAG_W(TAG_W)) u_sel (
    .we       (c_we),
    .tag      (c_tag),
    .l_st     (ca_st),
    .l_tag    (ca_tag),
    .hit      (c_hit),
    .local_ok (c_local_ok),
    .cmd      (c_cmd)
  );

  moesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .en     (snp_en),
    .cmd    (s_cmd),
    .tag    (snp_addr[ADDR_W-1:IDX_W]),
    .l_st   (sb_st),
    .l_tag  (sb_tag),
    .l_data (sb_data),
    .shared (snp_shared),
    .supply (snp_supply),
    .data   (snp_data),
    .upd_en (snp_upd),
    .upd_st (snp_nst)
  );

  // local line update: silent write hit or completion of our bus command
  always_comb begin
    a_wen   = 1'b0;
    a_wst   = ca_st;
    a_wtag  = ca_tag;
    a_wdata = ca_data;
    if (evt_local_hit && cpu_we) begin
      a_wen   = 1'b1;
      a_wst   = ST_M;
      a_wdata = cpu_wdata;
    end else if (evt_bus_done) begin
      a_wen = 1'b1;
      case (c_cmd)
        BC_WB:  a_wst = ST_I;
        BC_RD: begin
          a_wst   = st_after_fill(bus_shared_i);
          a_wtag  = c_tag;
          a_wdata = bus_rdata_i;
        end
        BC_RDX: begin
          a_wst   = ST_M;
          a_wtag  = c_tag;
          a_wdata = pend_data;
        end
        BC_UPG: begin
          a_wst   = ST_M;
          a_wdata = pend_data;
        end
        default: a_wen = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q     <= F_IDLE;
      pend_we   <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      done_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (fsm_q)
        F_IDLE: begin
          if (evt_accept) begin
            if (c_local_ok) begin
              done_q <= 1'b1;
              if (!cpu_we) rdata_q <= ca_data;
            end else begin
              fsm_q     <= F_REQ;
              pend_we   <= cpu_we;
              pend_addr <= cpu_addr;
              pend_data <= cpu_wdata;
            end
          end
        end
        default: begin
          if (evt_bus_done && (c_cmd != BC_WB)) begin
            done_q <= 1'b1;
            fsm_q  <= F_IDLE;
            if (c_cmd == BC_RD) rdata_q <= bus_rdata_i;
          end
        end
      endcase
    end
  end

  assign cpu_done    = done_q;
  assign cpu_rdata   = rdata_q;
  assign bus_req     = in_req;
  assign bus_cmd_o   = evt_bus_done ? c_cmd : BC_NONE;
  assign bus_addr_o  = (c_cmd == BC_WB) ? {ca_tag, c_idx} : pend_addr;
  assign bus_wdata_o = (c_cmd == BC_WB) ? ca_data : '0;

endmodule

// File: rtl/snoop_moesi_ctrl_chk.sv
`timescale 1ns/1ps
module snoop_moesi_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic [2:0] bus_cmd_o,
  input logic [2:0] snp_cmd,
  input logic       snp_shared,
  input logic       snp_supply,
  input logic       evt_local_hit
);

  AST_CMD_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o != 3'd0) |-> bus_gnt);  // R12

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);  // R12

  AST_SUPPLY_HAS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_shared);  // R8

  AST_SUPPLY_ON_READS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> ((snp_cmd == 3'd1) || (snp_cmd == 3'd2)));  // R8

  AST_QUIET_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |-> !snp_shared);  // R11

  AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o == 3'd4) |=> bus_req);  // R10

  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_local_hit |-> !bus_req);  // R3

endmodule

bind snoop_moesi_ctrl snoop_moesi_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_req       (bus_req),
  .bus_gnt       (bus_gnt),
  .bus_cmd_o     (bus_cmd_o),
  .snp_cmd       (snp_cmd),
  .snp_shared    (snp_shared),
  .snp_supply    (snp_supply),
  .evt_local_hit (evt_local_hit)
);

// File: tb/snoop_moesi_ctrl_test.sv
`timescale 1ns/1ps
module snoop_moesi_ctrl_test;

  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic bus_req;
  logic bus_gnt = 1'b0;
  logic [2:0] bus_cmd_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o;
  logic [DW-1:0] bus_rdata_i = '0;
  logic bus_shared_i = 1'b0;
  logic [2:0] snp_cmd = 3'd0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_shared, snp_supply;
  logic [DW-1:0] snp_data;

  always #5 clk = ~clk;

  snoop_moesi_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_o(bus_cmd_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i), .bus_shared_i(bus_shared_i),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_data(snp_data)
  );

  int checks = 0;
  int fails  = 0;
  bit reported = 0;
  logic [DW-1:0] mem [256];

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // op: 0 read, 1 write, 2 snoop; exp = rdata, or {shared,supply} for snoops
  typedef struct packed {
    logic [1:0]    op;
    logic [2:0]    scmd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          sh;
    logic [2:0]    c0;
    logic [2:0]    c1;
    logic [DW-1:0] exp;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 8'h10, 8'h00, 1'b0, 3'd1, 3'd0, 8'h4A},  // R2 miss -> E
    '{2'd0, 3'd0, 8'h10, 8'h00, 1'b0, 3'd0, 3'd0, 8'h4A},  // R3 hit
    '{2'd1, 3'd0, 8'h10, 8'h11, 1'b0, 3'd0, 3'd0, 8'h00},  // R4 E silent -> M
    '{2'd2, 3'd1, 8'h10, 8'h11, 1'b0, 3'd0, 3'd0, 8'h03},  // R7 M -> O supply
    '{2'd2, 3'd1, 8'h10, 8'h11, 1'b0, 3'd0, 3'd0, 8'h03},  // R7 O stays
    '{2'd1, 3'd0, 8'h10, 8'h22, 1'b0, 3'd3, 3'd0, 8'h00},  // R5 O upgrade
    '{2'd0, 3'd0, 8'h20, 8'h00, 1'b1, 3'd4, 3'd1, 8'h7A},  // R10 WB then RD -> S
    '{2'd1, 3'd0, 8'h20, 8'h33, 1'b0, 3'd3, 3'd0, 8'h00},  // R5 S upgrade
    '{2'd2, 3'd2, 8'h20, 8'h33, 1'b0, 3'd0, 3'd0, 8'h03},  // R9 RDX takes M
    '{2'd0, 3'd0, 8'h20, 8'h00, 1'b0, 3'd1, 3'd0, 8'h7A},  // R9 line was invalid
    '{2'd2, 3'd1, 8'h20, 8'h00, 1'b0, 3'd0, 3'd0, 8'h02},  // R7 E -> S
    '{2'd0, 3'd0, 8'h10, 8'h00, 1'b0, 3'd1, 3'd0, 8'h22},  // R10 silent S evict
    '{2'd2, 3'd3, 8'h10, 8'h00, 1'b0, 3'd0, 3'd0, 8'h00},  // R8 upgrade no reply
    '{2'd2, 3'd1, 8'h10, 8'h00, 1'b0, 3'd0, 3'd0, 8'h00},  // R9 upgrade invalidated
    '{2'd1, 3'd0, 8'h31, 8'h44, 1'b0, 3'd2, 3'd0, 8'h00},  // R6 write miss
    '{2'd0, 3'd0, 8'h31, 8'h00, 1'b0, 3'd0, 3'd0, 8'h44},  // R6 data kept
    '{2'd2, 3'd1, 8'h35, 8'h00, 1'b0, 3'd0, 3'd0, 8'h00},  // R8 tag mismatch
    '{2'd2, 3'd4, 8'h31, 8'h00, 1'b0, 3'd0, 3'd0, 8'h00},  // R9 WB ignored
    '{2'd2, 3'd1, 8'h31, 8'h44, 1'b0, 3'd0, 3'd0, 8'h03},  // R9 still M -> O
    '{2'd0, 3'd0, 8'h39, 8'h00, 1'b1, 3'd4, 3'd1, 8'h63},  // R10 O evict
    '{2'd0, 3'd0, 8'h31, 8'h00, 1'b0, 3'd1, 3'd0, 8'h44}   // R10 WB data reached mem
  };

  logic [2:0] got_c0, got_c1;
  logic [DW-1:0] got_rd;
  bit got_done;

  // processor access; bench acts as bus, arbiter and memory
  task automatic do_cpu(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic sh);
    int n;
    got_c0 = 3'd0; got_c1 = 3'd0; got_rd = '0; got_done = 0; n = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    for (int k = 0; k < 20; k++) begin
      if (bus_req) begin
        bus_gnt = 1'b1;
        #1;
        if (n == 0) got_c0 = bus_cmd_o; else got_c1 = bus_cmd_o;
        n++;
        if (bus_cmd_o == 3'd4) mem[bus_addr_o] = bus_wdata_o;
        else chk(bus_addr_o == a, "R2 bus address", bus_addr_o, a);
        bus_rdata_i  = mem[bus_addr_o];
        bus_shared_i = sh;
      end
      @(posedge clk); @(negedge clk);
      bus_gnt = 1'b0;
      if (cpu_done) begin
        got_rd = cpu_rdata;
        got_done = 1;
        break;
      end
    end
    cpu_req = 1'b0;
    chk(got_done, "R2 access completes", 0, 1);
  endtask

  task automatic do_snoop(input logic [2:0] c, input logic [AW-1:0] a,
                          output logic sh, output logic sp, output logic [DW-1:0] sd);
    snp_cmd = c; snp_addr = a;
    #1;
    sh = snp_shared; sp = snp_supply; sd = snp_data;
    @(posedge clk); @(negedge clk);
    snp_cmd = 3'd0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic sh, sp;
    logic [DW-1:0] sd;
    for (int i = 0; i < 256; i++) mem[i] = DW'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!bus_req, "R1 bus_req after reset", bus_req, 0);
    chk(!cpu_done, "R1 cpu_done after reset", cpu_done, 0);
    do_snoop(3'd1, 8'h10, sh, sp, sd);
    chk({sh, sp} == 2'b00, "R1 all lines invalid", {sh, sp}, 0);

    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      if (v.op == 2'd2) begin
        do_snoop(v.scmd, v.addr, sh, sp, sd);
        chk({sh, sp} == v.exp[1:0], $sformatf("R8 snoop response vec %0d", i), {sh, sp}, v.exp[1:0]);
        if (v.exp[0]) chk(sd == v.data, $sformatf("R7 supplied data vec %0d", i), sd, v.data);
      end else begin
        do_cpu(v.op[0], v.addr, v.data, v.sh);
        chk(got_c0 == v.c0, $sformatf("R10 first bus cmd vec %0d", i), got_c0, v.c0);
        chk(got_c1 == v.c1, $sformatf("R10 second bus cmd vec %0d", i), got_c1, v.c1);
        if (v.op == 2'd0) chk(got_rd == v.exp, $sformatf("R3 read data vec %0d", i), got_rd, v.exp);
      end
    end

    // R11: snoop during own grant is ignored
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h03;
    @(posedge clk); @(negedge clk);
    chk(bus_req, "R2 read miss requests bus", bus_req, 1);
    bus_gnt = 1'b1; snp_cmd = 3'd3; snp_addr = 8'h03;
    #1;
    chk(!snp_shared, "R11 no snoop reply in grant", snp_shared, 0);
    chk(bus_cmd_o == 3'd1, "R2 read command", bus_cmd_o, 1);
    bus_rdata_i = mem[8'h03]; bus_shared_i = 1'b0;
    @(posedge clk); @(negedge clk);
    bus_gnt = 1'b0; snp_cmd = 3'd0;
    chk(cpu_done && cpu_rdata == mem[8'h03], "R2 fill data", cpu_rdata, mem[8'h03]);
    cpu_req = 1'b0;
    do_snoop(3'd1, 8'h03, sh, sp, sd);
    chk({sh, sp} == 2'b10, "R11 line survived own-grant snoop", {sh, sp}, 2);

    // R11: pending upgrade loses its copy and becomes read-for-ownership
    do_cpu(1'b0, 8'h02, 8'h00, 1'b1);
    chk(got_c0 == 3'd1, "R2 read line 2", got_c0, 1);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h02; cpu_wdata = 8'h55;
    @(posedge clk); @(negedge clk);
    chk(bus_req, "R12 upgrade waits for bus", bus_req, 1);
    snp_cmd = 3'd3; snp_addr = 8'h02;
    @(posedge clk); @(negedge clk);
    snp_cmd = 3'd0;
    chk(bus_req, "R12 request held without grant", bus_req, 1);
    chk(bus_cmd_o == 3'd0, "R12 no command without grant", bus_cmd_o, 0);
    bus_gnt = 1'b1;
    #1;
    chk(bus_cmd_o == 3'd2, "R11 upgrade turned into RDX", bus_cmd_o, 2);
    bus_rdata_i = mem[8'h02];
    @(posedge clk); @(negedge clk);
    bus_gnt = 1'b0;
    chk(cpu_done, "R6 RDX completes", cpu_done, 1);
    cpu_req = 1'b0;
    do_snoop(3'd1, 8'h02, sh, sp, sd);
    chk({sh, sp} == 2'b11 && sd == 8'h55, "R6 line modified with write data", sd, 8'h55);

    finish_run();
  end

endmodule